// File: doc/BRIEF.md
# Two-Level Trigger Latency Buffer

This block stores the hit pattern from the front end on every bunch-crossing clock: one bit per channel, 256 bits wide. The words go into a circular pipeline memory. A first-level accept comes a fixed number of crossings after the crossing it selects. When it arrives, the block reads the word captured that many crossings earlier. It copies the word into a small event store and labels it with an event number generated on the chip.

A second-level request has no fixed latency and comes much less often. It names an event number. The block searches the event store for that number, copies the stored word into a one-deep response register and presents it on a valid/ready readout port. The entry is released once the consumer accepts the response. If the store has no matching entry, the block still returns a response, marked as an error.

Top module: `trig_latency_buf`

## Requirements
- R1: The pipeline write address advances by one on every clock outside reset and wraps after `PIPE_DEPTH` (a power of two) entries, so every crossing's `hit_in` word is stored.
- R2: A first-level accept sampled with `latency` = N (1 to PIPE_DEPTH-1) captures the `hit_in` word sampled N clocks earlier. With N = 0 it captures the word sampled PIPE_DEPTH clocks earlier.
- R3: Each first-level accept takes the next 8-bit event number. The numbers start at 0 after reset and wrap from 255 to 0. A number is used up even when its event is dropped.
- R4: A request taken on an edge (`req_valid` and `req_ready` high) gives `rd_valid` = 1 after that edge. The response carries `rd_id` equal to the requested number, `rd_err` = 0 and the stored word. Stored events can be requested in any order.
- R5: A request whose number matches no stored entry gives `rd_err` = 1, `rd_data` all zero and `rd_id` equal to the requested number.
- R6: While `rd_valid` = 1 and `rd_ready` = 0, the response stays unchanged and `req_ready` is 0. A pending request is not taken. The matched entry is released on the edge where `rd_valid` and `rd_ready` are both 1, so a second request for the same number gets an error response.
- R7: A first-level accept that arrives while all `EVB_DEPTH` entries are occupied is dropped. It sets `overflow`, which then stays at 1 until reset.
- R8: If two stored entries carry the same number, a request is served from the one stored first. The next request for that number is served from the other.
- R9: Synchronous reset clears `rd_valid`, `overflow`, every stored entry and the event-number counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_in | input | WIDTH | Hit word for this crossing |
| latency | input | $clog2(PIPE_DEPTH) | First-level latency in crossings |
| l0_accept | input | 1 | First-level accept |
| req_valid | input | 1 | Second-level request present |
| req_id | input | ID_W | Requested event number |
| req_ready | output | 1 | Request can be taken |
| rd_valid | output | 1 | Response present |
| rd_ready | input | 1 | Consumer takes response |
| rd_id | output | ID_W | Event number of the response |
| rd_err | output | 1 | No matching entry was found |
| rd_data | output | WIDTH | Stored hit word, zero on error |
| overflow | output | 1 | Sticky dropped-event flag |

## Verification
A word presented before edge c is captured by an accept presented before edge c+N. The bench therefore stamps every word with its own edge count and computes the expected word from the accept's edge count and the latency. A request presented before edge e appears on the readout port after edge e. The entry is released on the edge where the response is accepted. The bench drives all inputs on falling edges and samples results on the falling edge after the edge that produces them. Overflow and the event-number counter are checked after each event that should change them.

// File: rtl/trig_latency_buf.sv
module trig_latency_buf #(
  parameter int WIDTH      = 256,
  parameter int PIPE_DEPTH = 128,
  parameter int EVB_DEPTH  = 8,
  parameter int ID_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WIDTH-1:0]              hit_in,
  input  logic [$clog2(PIPE_DEPTH)-1:0] latency,
  input  logic                          l0_accept,
  input  logic                          req_valid,
  input  logic [ID_W-1:0]               req_id,
  output logic                          req_ready,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output logic [ID_W-1:0]               rd_id,
  output logic                          rd_err,
  output logic [WIDTH-1:0]              rd_data,
  output logic                          overflow
);
  localparam int PA_W = $clog2(PIPE_DEPTH);
  localparam int EA_W = $clog2(EVB_DEPTH);

  // circular pipeline
  logic [WIDTH-1:0] pipe_mem [PIPE_DEPTH];
  logic [PA_W-1:0]  wa;
  wire  [PA_W-1:0]  ra = wa - latency;

  always_ff @(posedge clk)
    if (rst) wa <= '0;
    else     wa <= wa + PA_W'(1);

  always_ff @(posedge clk)
    pipe_mem[wa] <= hit_in;

  a_r1_wa_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wa == $past(wa) + PA_W'(1));

  // event store
  logic [EVB_DEPTH-1:0] ev_valid;
  logic [ID_W-1:0]      ev_id   [EVB_DEPTH];
  logic [EA_W-1:0]      ev_rank [EVB_DEPTH];
  logic [WIDTH-1:0]     ev_data [EVB_DEPTH];
  logic [ID_W-1:0]      id_ctr;
  logic [EA_W-1:0]      hold_idx;
  logic [EA_W-1:0]      free_slot, m_idx, m_rank, new_rank;
  logic [EA_W:0]        nvalid;
  logic                 m_hit;

  wire ev_full  = &ev_valid;
  wire take_req = req_valid && req_ready;
  wire release_ev = rd_valid && rd_ready && !rd_err;

  assign req_ready = !rd_valid;

  always_comb begin
    free_slot = '0;
    nvalid    = '0;
    for (int i = EVB_DEPTH - 1; i >= 0; i--) begin
      if (!ev_valid[i]) free_slot = EA_W'(i);
      nvalid = nvalid + (EA_W+1)'(ev_valid[i]);
    end
    new_rank = EA_W'(nvalid - (EA_W+1)'(release_ev));
  end

  always_comb begin
    m_hit  = 1'b0;
    m_idx  = '0;
    m_rank = '1;
    for (int i = 0; i < EVB_DEPTH; i++)
      if (ev_valid[i] && ev_id[i] == req_id && (!m_hit || ev_rank[i] < m_rank)) begin
        m_hit  = 1'b1;
        m_idx  = EA_W'(i);
        m_rank = ev_rank[i];
      end
  end

  always_ff @(posedge clk)
    if (rst) begin
      ev_valid <= '0;
      id_ctr   <= '0;
      overflow <= 1'b0;
    end else begin
      if (release_ev) begin
        ev_valid[hold_idx] <= 1'b0;
        for (int i = 0; i < EVB_DEPTH; i++)
          if (ev_valid[i] && ev_rank[i] > ev_rank[hold_idx])
            ev_rank[i] <= ev_rank[i] - EA_W'(1);
      end
      if (l0_accept) begin
        id_ctr <= id_ctr + ID_W'(1);
        if (ev_full) overflow <= 1'b1;
        else begin
          ev_valid[free_slot] <= 1'b1;
          ev_id[free_slot]    <= id_ctr;
          ev_rank[free_slot]  <= new_rank;
          ev_data[free_slot]  <= pipe_mem[ra];
        end
      end
    end

  a_r3_id_step: assert property (@(posedge clk) disable iff (rst)
    l0_accept |=> id_ctr == $past(id_ctr) + ID_W'(1));
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r7_store_grows: assert property (@(posedge clk) disable iff (rst)
    l0_accept && !ev_full && !release_ev |=> nvalid == $past(nvalid) + (EA_W+1)'(1));

  // readout register
  always_ff @(posedge clk)
    if (rst) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_id    <= '0;
      rd_data  <= '0;
      hold_idx <= '0;
    end else if (take_req) begin
      rd_valid <= 1'b1;
      rd_id    <= req_id;
      rd_err   <= !m_hit;
      rd_data  <= m_hit ? ev_data[m_idx] : '0;
      hold_idx <= m_idx;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_id) && $stable(rd_err));
  a_r5_err_empty: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_err |-> rd_data == '0);
  a_r4_resp_id: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rd_valid && rd_id == $past(req_id));
endmodule

// File: tb/trig_latency_buf_bench.sv
module trig_latency_buf_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic [255:0] hit_in = '0;
  logic [6:0] latency = 7'd1;
  logic l0_accept = 1'b0, req_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] req_id = '0;
  logic req_ready, rd_valid, rd_err, overflow;
  logic [7:0] rd_id;
  logic [255:0] rd_data;

  trig_latency_buf u_trig_latency_buf (
    .clk(clk), .rst(rst), .hit_in(hit_in), .latency(latency), .l0_accept(l0_accept),
    .req_valid(req_valid), .req_id(req_id), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_id(rd_id), .rd_err(rd_err), .rd_data(rd_data), .overflow(overflow));

  always #5 clk = ~clk;

  int ecount = 0, nchk = 0, nfail = 0;
  logic [7:0] next_id = 0;
  always @(posedge clk) ecount <= ecount + 1;

  function automatic logic [255:0] pat(int c);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = (c * 32'h9E3779B1) ^ (k * 32'h01000193) ^ 32'(c);
    return r;
  endfunction

  always @(negedge clk) hit_in <= pat(ecount);

  localparam int NV = 8;
  localparam int LAT_TAB [NV] = '{1, 2, 5, 64, 127, 0, 33, 100};
  localparam int DLY_TAB [NV] = '{1, 2, 5, 64, 127, 128, 33, 100};

  task automatic chk(string r, logic [255:0] act, logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic l0(int lat, int dly, output logic [255:0] exp, output logic [7:0] id);
    @(negedge clk);
    latency = 7'(lat);
    l0_accept = 1'b1;
    exp = pat(ecount - dly);
    id = next_id;
    next_id++;
    @(negedge clk);
    l0_accept = 1'b0;
  endtask

  task automatic req(logic [7:0] id, output logic err, output logic [7:0] rid, output logic [255:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_id = id;
    @(negedge clk);
    req_valid = 1'b0;
    err = rd_err; rid = rd_id; d = rd_data;
    chk("R4 valid", 256'(rd_valid), 256'(1));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic get_ok(string r, logic [7:0] id, logic [255:0] exp);
    logic e; logic [7:0] rid; logic [255:0] d;
    req(id, e, rid, d);
    chk({r, " err"}, 256'(e), 256'(0));
    chk({r, " id"}, 256'(rid), 256'(id));
    chk({r, " data"}, d, exp);
  endtask

  task automatic get_err(string r, logic [7:0] id);
    logic e; logic [7:0] rid; logic [255:0] d;
    req(id, e, rid, d);
    chk({r, " err"}, 256'(e), 256'(1));
    chk({r, " id"}, 256'(rid), 256'(id));
    chk({r, " data"}, d, '0);
  endtask

  initial begin
    logic [255:0] ex, exa, exb, exc;
    logic [7:0] ia, ib, ic, first_id, drop_id, ids [8];
    logic [255:0] exs [8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 rd_valid", 256'(rd_valid), 256'(0));
    chk("R9 overflow", 256'(overflow), 256'(0));
    chk("R6 req_ready", 256'(req_ready), 256'(1));
    repeat (140) @(negedge clk);

    // R1/R2 latency table, including wrap (latency 0 = full depth)
    for (int i = 0; i < NV; i++) begin
      l0(LAT_TAB[i], DLY_TAB[i], ex, ia);
      get_ok("R2", ia, ex);
    end
    chk("R3 id count", 256'(ia), 256'(NV - 1));

    get_err("R5", 8'hEE);

    // R6 stall
    l0(7, 7, ex, ia);
    @(negedge clk); req_valid = 1'b1; req_id = ia;
    @(negedge clk); req_id = 8'h55;
    repeat (3) @(negedge clk);
    chk("R6 stall valid", 256'(rd_valid), 256'(1));
    chk("R6 stall ready", 256'(req_ready), 256'(0));
    chk("R6 stall id", 256'(rd_id), 256'(ia));
    chk("R6 stall data", rd_data, ex);
    req_valid = 1'b0; rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
    chk("R6 released", 256'(rd_valid), 256'(0));
    get_err("R6 freed", ia);

    // R4 out of order
    l0(3, 3, exa, ia); l0(9, 9, exb, ib); l0(20, 20, exc, ic);
    get_ok("R4 c", ic, exc); get_ok("R4 a", ia, exa); get_ok("R4 b", ib, exb);

    // R7 overflow
    for (int i = 0; i < 8; i++) l0(4 + i, 4 + i, exs[i], ids[i]);
    chk("R7 not yet", 256'(overflow), 256'(0));
    l0(4, 4, ex, drop_id);
    chk("R7 set", 256'(overflow), 256'(1));
    get_err("R7 dropped", drop_id);
    get_ok("R7 kept", ids[0], exs[0]);
    l0(6, 6, ex, ia);
    chk("R3 consumed", 256'(ia), 256'(drop_id + 8'd1));
    get_ok("R7 after", ia, ex);
    chk("R7 sticky", 256'(overflow), 256'(1));
    for (int i = 1; i < 8; i++) get_ok("R7 drain", ids[i], exs[i]);

    // R8 duplicate ids, oldest first
    l0(11, 11, exa, first_id);
    for (int i = 0; i < 255; i++) begin
      l0(2, 2, ex, ia);
      get_ok("R3 wrap", ia, ex);
    end
    l0(13, 13, exb, ib);
    chk("R3 wrapped", 256'(ib), 256'(first_id));
    get_ok("R8 oldest", first_id, exa);
    get_ok("R8 second", first_id, exb);

    // R9 reset
    l0(5, 5, ex, ia);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R9 ovf clr", 256'(overflow), 256'(0));
    chk("R9 rd clr", 256'(rd_valid), 256'(0));
    get_err("R9 store clr", ia);
    next_id = 0;
    repeat (140) @(negedge clk);
    l0(8, 8, ex, ia);
    get_ok("R9 id zero", 8'd0, ex);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule